// File: doc/BRIEF.md
# Frame Buffer Region Request Generator

This block sits between an incoming video stream and the engine that writes frames into external memory. The memory holds four frame regions. The block watches the frame-valid level of the video and treats each low-to-high transition as the start of a new frame.

For each new frame it picks the region that receives the frame. It then raises a request toward the writer. The request lasts a minimum pulse and is closed by the writer's acknowledge.

The block also publishes a read region for the display side. The read region always names the region that was written most recently, so it trails the write region by one completed frame. For each region index, a combinational base address is given.

Top module: `fb_region_sequencer`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `wr_req` is 0, both region indices are 0 and both base addresses equal `BASE_ORIGIN` (0).
- R2: A low-to-high change of `frame_valid`, sampled at a clock edge, makes `wr_req` read 1 after that edge. A `frame_valid` level that stays high or falls never raises `wr_req`.
- R3: Once raised, `wr_req` stays high for at least `PULSE_CYC` (2) cycles. If `wr_ack` was sampled high during those cycles, the request drops after exactly 2 cycles.
- R4: If no acknowledge has been sampled by the end of the minimum pulse, `wr_req` stays high until the edge that samples `wr_ack` high, and reads 0 after that edge.
- R5: The first request after reset writes region 0, and the read region stays 0.
- R6: Every later request moves the write region up by one, modulo 4, so region 3 is followed by region 0. In the same cycle, the read region takes the previous write region. The indices change only in the cycle in which `wr_req` rises.
- R7: If `frame_valid` is high while reset is released, no request is issued until `frame_valid` has fallen and risen again.
- R8: A frame-valid rising edge sampled while a request is active, including the edge that closes it, is kept pending. After the close, `wr_req` is low for exactly one cycle, and the indices stay unchanged during that cycle. A new request then starts with advanced indices.
- R9: `wr_base` and `rd_base` equal `BASE_ORIGIN + index * REGION_STRIDE`, with `REGION_STRIDE` = 2073600. This gives 0, 2073600, 4147200 and 6220800 for indices 0 to 3.
- R10: `wr_ack` sampled while `wr_req` is low has no effect. A later request still waits for its own acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_valid | input | 1 | Frame-valid level of the incoming video |
| wr_ack | input | 1 | Acknowledge from the frame writer |
| wr_req | output | 1 | Write request to the frame writer |
| wr_region | output | 2 | Region that receives the current frame |
| rd_region | output | 2 | Region that the display side should fetch |
| wr_base | output | ADDR_W | Base address of the write region |
| rd_base | output | ADDR_W | Base address of the read region |

## Verification
Two events can fall on the same clock edge: the acknowledge that closes a request, and a new frame-valid rising edge. The bench sets up this case by dropping `frame_valid` in the first request cycle. In the second cycle it raises `frame_valid` and `wr_ack` together. It then expects one low cycle of `wr_req` with the old indices, followed by a new request whose write and read regions have both moved on. A lost frame would show up as a missing second request, and a merged request would show up as no low cycle.

// File: rtl/fb_region_sequencer.sv
module fb_region_sequencer #(
  parameter int ADDR_W        = 25,
  parameter int SLOT_W        = 2,
  parameter int PULSE_CYC     = 2,
  parameter int BASE_ORIGIN   = 0,
  parameter int REGION_STRIDE = 2073600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_valid,
  input  logic              wr_ack,
  output logic              wr_req,
  output logic [SLOT_W-1:0] wr_region,
  output logic [SLOT_W-1:0] rd_region,
  output logic [ADDR_W-1:0] wr_base,
  output logic [ADDR_W-1:0] rd_base
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic             fv_q;
  logic             started;
  logic             pending;
  logic             ack_seen;
  logic [CNT_W-1:0] hi_cnt;

  wire rise   = frame_valid & ~fv_q;
  wire closes = wr_req && (hi_cnt >= CNT_W'(PULSE_CYC)) && (ack_seen || wr_ack);
  wire launch = !wr_req && (rise || pending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fv_q <= 1'b1;
    else        fv_q <= frame_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_req   <= 1'b0;
      hi_cnt   <= '0;
      ack_seen <= 1'b0;
      pending  <= 1'b0;
    end else if (launch) begin
      wr_req   <= 1'b1;
      hi_cnt   <= CNT_W'(1);
      ack_seen <= 1'b0;
      pending  <= 1'b0;
    end else if (wr_req) begin
      if (rise) pending <= 1'b1;
      if (closes) begin
        wr_req   <= 1'b0;
        hi_cnt   <= '0;
        ack_seen <= 1'b0;
      end else begin
        if (wr_ack) ack_seen <= 1'b1;
        if (hi_cnt < CNT_W'(PULSE_CYC)) hi_cnt <= hi_cnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started   <= 1'b0;
      wr_region <= '0;
      rd_region <= '0;
    end else if (launch) begin
      if (started) begin
        rd_region <= wr_region;
        wr_region <= wr_region + SLOT_W'(1);
      end else begin
        started <= 1'b1;
      end
    end
  end

  assign wr_base = ADDR_W'(BASE_ORIGIN) + ADDR_W'(wr_region) * ADDR_W'(REGION_STRIDE);
  assign rd_base = ADDR_W'(BASE_ORIGIN) + ADDR_W'(rd_region) * ADDR_W'(REGION_STRIDE);
endmodule

// File: rtl/fb_region_sequencer_chk.sv
module fb_region_sequencer_chk #(
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_ack,
  input logic              wr_req,
  input logic [SLOT_W-1:0] wr_region,
  input logic [SLOT_W-1:0] rd_region
);
  logic ack_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ack_hist <= 1'b0;
    else if (!wr_req) ack_hist <= 1'b0;
    else if (wr_ack)  ack_hist <= 1'b1;
  end

  p_min_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req) |=> wr_req);

  p_drop_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_req) |-> ack_hist);

  p_wr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_region) |-> wr_region == SLOT_W'($past(wr_region) + 1'b1));

  p_rd_trails_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_region) |-> rd_region == $past(wr_region));

  p_move_on_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_region) |-> $rose(wr_req));
endmodule

bind fb_region_sequencer fb_region_sequencer_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ack(wr_ack), .wr_req(wr_req),
  .wr_region(wr_region), .rd_region(rd_region)
);

// File: tb/sim_fb_region_sequencer.sv
`timescale 1ns/1ps
module sim_fb_region_sequencer;
  localparam int STRIDE = 2073600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_valid = 1'b0;
  logic        wr_ack = 1'b0;
  logic        wr_req;
  logic [1:0]  wr_region, rd_region;
  logic [24:0] wr_base, rd_base;

  int runs = 0;
  int fails = 0;
  int exp_wr = 0, exp_rd = 0;
  bit started = 0;

  always #4 clk = ~clk;

  fb_region_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .wr_ack(wr_ack),
    .wr_req(wr_req), .wr_region(wr_region), .rd_region(rd_region),
    .wr_base(wr_base), .rd_base(rd_base)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic model_launch();
    if (started) begin
      exp_rd = exp_wr;
      exp_wr = (exp_wr + 1) % 4;
    end else begin
      started = 1;
    end
  endtask

  task automatic chk_regions(input string tag);
    chk(wr_region == 2'(exp_wr), {tag, " wr_region"}, wr_region, exp_wr);
    chk(rd_region == 2'(exp_rd), {tag, " rd_region"}, rd_region, exp_rd);
    chk(wr_base == 25'(exp_wr * STRIDE), "R9 wr_base", wr_base, exp_wr * STRIDE);
    chk(rd_base == 25'(exp_rd * STRIDE), "R9 rd_base", rd_base, exp_rd * STRIDE);
  endtask

  task automatic do_reset(input bit fv_level);
    rst_n = 1'b0; wr_ack = 1'b0; frame_valid = fv_level;
    exp_wr = 0; exp_rd = 0; started = 0;
    repeat (3) step();
    chk(wr_req == 1'b0, "R1 req in reset", wr_req, 0);
    rst_n = 1'b1;
    step();
    chk(wr_req == 1'b0, "R1 req after reset", wr_req, 0);
    chk_regions("R1");
  endtask

  // Raise frame_valid, then ack in request cycle ack_at (1-based).
  task automatic run_frame(input int ack_at, input string tag);
    int span;
    span = (ack_at > 2) ? ack_at : 2;
    frame_valid = 1'b1;
    step();
    model_launch();
    chk_regions(tag);
    for (int k = 1; k <= span; k++) begin
      chk(wr_req == 1'b1, (ack_at > 2) ? "R4 req held" : "R3 req pulse", wr_req, 1);
      wr_ack = (k == ack_at);
      step();
    end
    wr_ack = 1'b0;
    chk(wr_req == 1'b0, (ack_at > 2) ? "R4 req dropped" : "R3 req dropped", wr_req, 0);
    step();
    chk(wr_req == 1'b0, "R2 level high no request", wr_req, 0);
    frame_valid = 1'b0;
    step();
    chk(wr_req == 1'b0, "R2 falling no request", wr_req, 0);
  endtask

  task automatic t_basic();
    do_reset(1'b0);
    run_frame(1, "R5 first frame");
    run_frame(2, "R6 second frame");
    run_frame(1, "R6 third frame");
    run_frame(2, "R6 fourth frame");
    run_frame(1, "R6 wrap to region 0");
  endtask

  task automatic t_late_ack();
    run_frame(5, "R6 late-ack frame");
  endtask

  task automatic t_stray_ack();
    wr_ack = 1'b1;
    repeat (2) step();
    chk(wr_req == 1'b0, "R10 idle ack no request", wr_req, 0);
    wr_ack = 1'b0;
    run_frame(4, "R10 after stray ack");
  endtask

  task automatic t_fv_across_reset();
    do_reset(1'b1);
    repeat (5) step();
    chk(wr_req == 1'b0, "R7 no request from held level", wr_req, 0);
    frame_valid = 1'b0;
    step();
    run_frame(2, "R7 first real frame");
  endtask

  task automatic t_collision();
    frame_valid = 1'b1;
    step();
    model_launch();
    chk(wr_req == 1'b1, "R8 first request", wr_req, 1);
    frame_valid = 1'b0;
    step();
    chk(wr_req == 1'b1, "R8 first request cycle 2", wr_req, 1);
    frame_valid = 1'b1;
    wr_ack = 1'b1;
    step();
    wr_ack = 1'b0;
    chk(wr_req == 1'b0, "R8 one low cycle", wr_req, 0);
    chk_regions("R8 indices held in gap");
    step();
    model_launch();
    chk(wr_req == 1'b1, "R8 pending request launched", wr_req, 1);
    chk_regions("R8 advanced indices");
    step();
    wr_ack = 1'b1;
    step();
    wr_ack = 1'b0;
    chk(wr_req == 1'b0, "R8 pending request closed", wr_req, 0);
    frame_valid = 1'b0;
    step();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    t_basic();
    t_late_ack();
    t_stray_ack();
    t_collision();
    t_fv_across_reset();
    t_collision();
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule